// File: doc/BRIEF.md
# Serial Boot Loader with End-Marker Word

This block owns the instruction memory write port while the processor is held after reset. It listens on a dedicated serial receive line, recovers bytes framed as one start bit, eight data bits sent least significant bit first, and one stop bit. It groups every four bytes into a 32-bit instruction word and writes each word to the next word address of instruction memory, beginning at address zero.

The stream ends with a fixed in-band marker word, 0xBAADF00D. When a complete word equal to the marker is assembled, it is not stored. Instead the block raises its run output, which releases the processor. The run output then stays high until the next reset, and any further serial traffic is ignored.

A stream longer than the memory is clipped rather than wrapped. Once every word location has been filled, later words are dropped without a write, but the marker still releases the processor.

Top module: `uart_boot_loader`

## Requirements
- R1: While reset (rst_n low, sampled on the rising clock edge) is applied and in the cycles right after it, cpu_run_o is 0 and imem_we_o is 0.
- R2: The receiver takes 8N1 frames of CLKS_PER_BIT clocks per bit. It checks the start bit at its middle, samples each data bit at mid-bit, and assembles the data bits least significant bit first.
- R3: Four received bytes form one word, little-endian: the first byte lands in bits 7:0 and the fourth byte lands in bits 31:24.
- R4: Each assembled non-marker word is written with a single-cycle imem_we_o pulse. The word address is 0 for the first word and rises by one for each later word.
- R5: A word equal to 0xBAADF00D is never written. Its arrival sets cpu_run_o to 1, and cpu_run_o stays 0 until then.
- R6: Once cpu_run_o is 1, it stays 1 until reset, and imem_we_o stays 0.
- R7: Bytes received after cpu_run_o has risen cause no write and do not change cpu_run_o.
- R8: A frame whose stop bit reads 0 is discarded and contributes no byte. Reception resumes only after the line has returned high.
- R9: At most DEPTH words are written. Later non-marker words are dropped with no write, and a following marker still sets cpu_run_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| imem_we_o | output | 1 | Instruction memory write enable, one cycle per word |
| imem_addr_o | output | AW | Word address of the write |
| imem_wdata_o | output | 32 | Instruction word to write |
| cpu_run_o | output | 1 | Processor release, high after the marker word |

## Verification
The hardest state to reach is the memory-full condition. To get there, the stimulus sends more words than the bench-sized memory can hold, and only then sends the marker. This shows that the extra words are dropped and that the marker still takes effect. A frame with a deliberately low stop bit is inserted just before four good bytes. The next write must then contain only the good bytes, which confirms that the bad frame did not shift the byte order. Traffic sent after release is checked at the write port and at the run output.

// File: rtl/boot_pkg.sv
package boot_pkg;
    localparam logic [31:0] END_MARK = 32'hBAAD_F00D;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HIGH
    } rx_state_e;

    typedef struct packed {
        logic        vld;
        logic [7:0]  data;
    } byte_t;

    typedef struct packed {
        logic        vld;
        logic [31:0] data;
    } word_t;

    function automatic logic is_end_mark(input logic [31:0] w);
        return w == END_MARK;
    endfunction
endpackage

// File: rtl/serial_rx.sv
module serial_rx
    import boot_pkg::*;
#(
    parameter int CLKS_PER_BIT = 868,
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rx_i,
    output byte_t byte_o
);
    localparam logic [CW-1:0] FULL = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] HALF = CW'(CLKS_PER_BIT / 2 - 1);

    logic [1:0]  sync_q;
    logic        line;
    rx_state_e   st_q;
    logic [CW-1:0] cnt_q;
    logic [2:0]  bit_q;
    logic [7:0]  sh_q;

    assign line = sync_q[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            st_q   <= RX_IDLE;
            cnt_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            byte_o <= '0;
        end else begin
            sync_q     <= {sync_q[0], rx_i};
            byte_o.vld <= 1'b0;
            case (st_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    if (!line) st_q <= RX_START;
                end
                RX_START: begin
                    if (cnt_q == HALF) begin
                        cnt_q <= '0;
                        bit_q <= '0;
                        st_q  <= line ? RX_IDLE : RX_DATA;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                RX_DATA: begin
                    if (cnt_q == FULL) begin
                        cnt_q <= '0;
                        sh_q  <= {line, sh_q[7:1]};
                        if (bit_q == 3'd7) st_q <= RX_STOP;
                        bit_q <= bit_q + 1'b1;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                RX_STOP: begin
                    if (cnt_q == FULL) begin
                        cnt_q <= '0;
                        if (line) begin
                            byte_o.vld  <= 1'b1;
                            byte_o.data <= sh_q;
                            st_q        <= RX_IDLE;
                        end else st_q <= RX_WAIT_HIGH;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                default: if (line) st_q <= RX_IDLE;
            endcase
        end
    end

    // R2
    byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_o.vld |=> !byte_o.vld);
    // R8
    bad_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_WAIT_HIGH) |-> !byte_o.vld);
endmodule

// File: rtl/word_packer.sv
module word_packer
    import boot_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  byte_t byte_i,
    output word_t word_o
);
    logic [1:0]  idx_q;
    logic [23:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            acc_q  <= '0;
            word_o <= '0;
        end else begin
            word_o.vld <= 1'b0;
            if (byte_i.vld) begin
                idx_q <= idx_q + 1'b1;
                if (idx_q == 2'd3) begin
                    word_o.vld  <= 1'b1;
                    word_o.data <= {byte_i.data, acc_q};
                end else begin
                    acc_q <= {byte_i.data, acc_q[23:8]};
                end
            end
        end
    end

    // R3
    word_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_o.vld |-> $past(byte_i.vld));
endmodule

// File: rtl/boot_ctrl.sv
module boot_ctrl
    import boot_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  word_t         word_i,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [31:0]   wdata_o,
    output logic          run_o
);
    logic [AW:0] fill_q;
    logic        room;

    assign room = fill_q < (AW+1)'(DEPTH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q  <= '0;
            we_o    <= 1'b0;
            addr_o  <= '0;
            wdata_o <= '0;
            run_o   <= 1'b0;
        end else begin
            we_o <= 1'b0;
            if (word_i.vld && !run_o) begin
                if (is_end_mark(word_i.data)) begin
                    run_o <= 1'b1;
                end else if (room) begin
                    we_o    <= 1'b1;
                    addr_o  <= fill_q[AW-1:0];
                    wdata_o <= word_i.data;
                    fill_q  <= fill_q + 1'b1;
                end
            end
        end
    end

    // R6
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |=> run_o);
    // R6
    no_write_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> !we_o);
    // R5
    marker_not_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> (wdata_o != END_MARK));
    // R4
    write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> $past(word_i.vld));
endmodule

// File: rtl/uart_boot_loader.sv
module uart_boot_loader
    import boot_pkg::*;
#(
    parameter int CLKS_PER_BIT = 868,
    parameter int DEPTH = 1024,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_i,
    output logic          imem_we_o,
    output logic [AW-1:0] imem_addr_o,
    output logic [31:0]   imem_wdata_o,
    output logic          cpu_run_o
);
    byte_t rx_byte;
    word_t packed_word;

    serial_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .byte_o(rx_byte)
    );

    word_packer u_pack (
        .clk(clk), .rst_n(rst_n), .byte_i(rx_byte), .word_o(packed_word)
    );

    boot_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .word_i(packed_word),
        .we_o(imem_we_o), .addr_o(imem_addr_o), .wdata_o(imem_wdata_o),
        .run_o(cpu_run_o)
    );
endmodule

// File: tb/tb_uart_boot_loader.sv
module tb_uart_boot_loader;
    localparam int CLK_PERIOD = 10;
    localparam int CPB = 8;
    localparam int DEPTH = 4;
    localparam int AW = 2;
    localparam logic [31:0] MARK = 32'hBAAD_F00D;
    localparam int NVEC = 3;
    localparam logic [31:0] VEC [NVEC] = '{32'h1234_5678, 32'h0000_0013, 32'hA5C3_0FF1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 1'b1;
    logic we, run;
    logic [AW-1:0] addr;
    logic [31:0] wdata;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    int nlog = 0;
    logic [31:0] log_d [16];
    logic [AW-1:0] log_a [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_boot_loader #(.CLKS_PER_BIT(CPB), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .imem_we_o(we),
        .imem_addr_o(addr), .imem_wdata_o(wdata), .cpu_run_o(run)
    );

    always @(negedge clk) if (we && nlog < 16) begin
        log_d[nlog] = wdata;
        log_a[nlog] = addr;
        nlog = nlog + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bit_time(input logic v);
        rx = v;
        repeat (CPB) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop);
        bit_time(1'b0);
        for (int i = 0; i < 8; i++) bit_time(b[i]);
        bit_time(stop);
        bit_time(1'b1);
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 0; i < 4; i++) send_byte(w[8*i +: 8], 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rx = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        nlog = 0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (2) @(negedge clk);
        chk("R1 run in reset", run, 0);
        chk("R1 we in reset", we, 0);
        do_reset();
        chk("R1 run after reset", run, 0);
        chk("R1 we after reset", we, 0);

        // R2 R3 R4 R5 table walk
        for (int i = 0; i < NVEC; i++) send_word(VEC[i]);
        repeat (4) @(negedge clk);
        chk("R5 run before marker", run, 0);
        send_word(MARK);
        repeat (4) @(negedge clk);
        chk("R4 write count", nlog, NVEC);
        for (int i = 0; i < NVEC; i++) begin
            chk("R3 word data", log_d[i], VEC[i]);
            chk("R4 word addr", 32'(log_a[i]), i);
        end
        chk("R5 run after marker", run, 1);

        // R7 traffic after release
        send_word(32'hDEAD_0001);
        send_word(MARK);
        repeat (4) @(negedge clk);
        chk("R7 no write after run", nlog, NVEC);
        chk("R6 run held", run, 1);

        // R8 bad stop bit frame
        do_reset();
        send_byte(8'h55, 1'b0);
        send_word(32'h0BAD_CAFE);
        repeat (4) @(negedge clk);
        chk("R8 one write", nlog, 1);
        chk("R8 aligned data", log_d[0], 32'h0BAD_CAFE);
        chk("R8 addr 0", 32'(log_a[0]), 0);

        // R9 saturation
        do_reset();
        for (int i = 0; i < DEPTH + 2; i++) send_word(32'h100 + i);
        repeat (4) @(negedge clk);
        chk("R9 write count clipped", nlog, DEPTH);
        chk("R9 last addr", 32'(log_a[DEPTH-1]), DEPTH-1);
        chk("R9 last data", log_d[DEPTH-1], 32'h100 + DEPTH - 1);
        chk("R9 run before marker", run, 0);
        send_word(MARK);
        repeat (4) @(negedge clk);
        chk("R9 run after marker", run, 1);

        // R5 marker first
        do_reset();
        send_word(MARK);
        repeat (4) @(negedge clk);
        chk("R5 no write", nlog, 0);
        chk("R5 run set", run, 1);

        // R1 reset clears run
        do_reset();
        chk("R1 run cleared", run, 0);

        finish_run();
    end
endmodule